// File: doc/BRIEF.md
# Column-Compressing Unsigned Array Multiplier

This block multiplies two unsigned operands in pure combinational logic. Every partial-product bit `x[i] & y[j]` is formed at once and filed into the output column of weight `i + j`, so that each column collects the crosswise products of its diagonal. Each column is then collapsed by a counting compressor: a unit that takes the column's bits and emits their population count in binary. Bit `k` of a count taken in column `c` lands in column `c + k`.

A second layer of fixed-size counting compressors reduces the re-gathered columns to a handful of rows. A single carry-propagate addition then merges those rows into the product. The operand width is a parameter. The default build is 8 x 8 giving 16 bits, and the same structure elaborates as 16 x 16 giving 32 bits. There is no clock, no register and no signed mode, so the product follows the operands after the logic settles.

Top module: `vcm_mul`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals the arithmetic product `x * y`, taken as a 2*WIDTH-bit value.
- R2: The block is combinational: a change on `x` or `y` shows on `prod` without any clock edge.
- R3: The product never overflows 2*WIDTH bits; 255 x 255 gives 65025 (hex FE01) in the 8-bit build, with all internal row-sum bits above bit 2*WIDTH-1 zero.
- R4: If either operand is zero, `prod` is zero.
- R5: If one operand is 1, `prod` equals the other operand, zero-extended.
- R6: Each counting compressor outputs the binary number of ones among its inputs.
- R7: The partial product of operand bits i and j carries weight 2^(i+j): `x = 1<<i`, `y = 1<<j` gives `prod = 1<<(i+j)`.
- R8: 136 x 119 gives 16184 and 141 x 124 gives 17484 (decimal).
- R9: Setting WIDTH to 16 builds a 16 x 16 multiplier with a 32-bit product that meets R1.
- R10: A WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | Multiplicand, unsigned |
| y | input | WIDTH | Multiplier, unsigned |
| prod | output | 2*WIDTH | Unsigned product |

## Verification
The 8-bit build is swept over all 65536 operand pairs. This exposes any misrouted partial product or compressor output bit, because each one breaks a whole class of pairs. Single-bit operand pairs isolate column weighting. Zero, one and all-ones operands separate the empty, identity and full-height column cases, and all-ones also drives the top carry. The 16-bit build is sampled with random operands plus the all-ones corner, which shows that the parameterized column gathering scales beyond the default.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

   // width of a binary count of up to n ones
   function automatic int cnt_w(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/vcm_counter.sv
module vcm_counter #(
   parameter int N_IN = 4,
   localparam int CW = vcm_pkg::cnt_w(N_IN)
) (
   input  logic [N_IN-1:0] bits_in,
   output logic [CW-1:0]   count
);

   generate
      if (N_IN < 1) begin : g_bad_size
         $error("vcm_counter: N_IN must be at least 1");
      end
   endgenerate

   always_comb begin
      count = '0;
      for (int i = 0; i < N_IN; i++) begin
         count = count + CW'(bits_in[i]);
      end
   end

   // R6: count must match the ones population of the inputs
   always_comb begin
      a_r6_count_matches: assert (int'(count) == $countones(bits_in))
         else $error("vcm_counter: count %0d for input %b", count, bits_in);
   end

endmodule

// File: rtl/vcm_pp_columns.sv
module vcm_pp_columns #(
   parameter int WIDTH = 8,
   localparam int NCOL = 2 * WIDTH - 1,
   localparam int W1   = vcm_pkg::cnt_w(WIDTH)
) (
   input  logic [WIDTH-1:0]           x,
   input  logic [WIDTH-1:0]           y,
   output logic [NCOL-1:0][W1-1:0]    col_cnt
);

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_col
         localparam int LO = (c < WIDTH) ? 0 : c - WIDTH + 1;
         localparam int HT = (c < WIDTH) ? c + 1 : NCOL - c;
         localparam int CW = vcm_pkg::cnt_w(HT);

         logic [HT-1:0] diag;
         logic [CW-1:0] cnt;

         for (genvar k = 0; k < HT; k++) begin : g_pp
            assign diag[k] = x[LO + k] & y[c - LO - k];
         end

         vcm_counter #(.N_IN(HT)) u_cnt (
            .bits_in (diag),
            .count   (cnt)
         );

         assign col_cnt[c] = W1'(cnt);
      end
   endgenerate

endmodule

// File: rtl/vcm_row_reducer.sv
module vcm_row_reducer #(
   parameter int WIDTH = 8,
   localparam int NCOL = 2 * WIDTH - 1,
   localparam int W1   = vcm_pkg::cnt_w(WIDTH),
   localparam int W2   = vcm_pkg::cnt_w(W1),
   localparam int ROWW = 2 * WIDTH + W1,
   localparam int RW2  = ROWW + W2
) (
   input  logic [NCOL-1:0][W1-1:0]  col_cnt,
   output logic [W2-1:0][RW2-1:0]   rows_out
);

   logic [W1-1:0][ROWW-1:0] rows_mid;
   logic [ROWW-1:0][W2-1:0] cnt2;

   // scatter first-layer counts: bit j of column c weighs c+j
   always_comb begin
      rows_mid = '0;
      for (int c = 0; c < NCOL; c++) begin
         for (int j = 0; j < W1; j++) begin
            rows_mid[j][c + j] = col_cnt[c][j];
         end
      end
   end

   generate
      for (genvar c = 0; c < ROWW; c++) begin : g_col2
         logic [W1-1:0] stack;
         for (genvar j = 0; j < W1; j++) begin : g_pick
            assign stack[j] = rows_mid[j][c];
         end

         vcm_counter #(.N_IN(W1)) u_cnt2 (
            .bits_in (stack),
            .count   (cnt2[c])
         );
      end
   endgenerate

   always_comb begin
      rows_out = '0;
      for (int c = 0; c < ROWW; c++) begin
         for (int k = 0; k < W2; k++) begin
            rows_out[k][c + k] = cnt2[c][k];
         end
      end
   end

endmodule

// File: rtl/vcm_mul.sv
module vcm_mul #(
   parameter int WIDTH = 8,
   localparam int PW   = 2 * WIDTH,
   localparam int W1   = vcm_pkg::cnt_w(WIDTH),
   localparam int W2   = vcm_pkg::cnt_w(W1),
   localparam int RW2  = PW + W1 + W2,
   localparam int NCOL = PW - 1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [PW-1:0]    prod
);

   // R10: elaboration guard
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("vcm_mul: WIDTH must be 2 or more");
      end
   endgenerate

   logic [NCOL-1:0][W1-1:0] col_cnt;
   logic [W2-1:0][RW2-1:0]  rows;
   logic [RW2-1:0]          total;

   vcm_pp_columns #(.WIDTH(WIDTH)) u_cols (
      .x       (x),
      .y       (y),
      .col_cnt (col_cnt)
   );

   vcm_row_reducer #(.WIDTH(WIDTH)) u_rows (
      .col_cnt  (col_cnt),
      .rows_out (rows)
   );

   // final carry-propagate merge of the remaining rows
   always_comb begin
      total = '0;
      for (int k = 0; k < W2; k++) begin
         total = total + rows[k];
      end
   end

   assign prod = total[PW-1:0];

   always_comb begin
      // R3: nothing may spill beyond the product width
      a_r3_no_overflow: assert (total[RW2-1:PW] == '0)
         else $error("vcm_mul: spill above product width");
      // R1: compressor tree result equals the arithmetic product
      a_r1_exact_product: assert (prod == ({{WIDTH{1'b0}}, x} * {{WIDTH{1'b0}}, y}))
         else $error("vcm_mul: %0d * %0d gave %0d", x, y, prod);
      // R4: a zero operand forces a zero product
      a_r4_zero_operand: assert (!(x == '0 || y == '0) || prod == '0)
         else $error("vcm_mul: zero operand gave %0d", prod);
      // R5: unit operand passes the other through
      a_r5_unit_operand: assert (!(y == WIDTH'(1)) || prod == PW'(x))
         else $error("vcm_mul: unit operand gave %0d", prod);
   end

endmodule

// File: tb/tb_vcm_mul.sv
module tb_vcm_mul;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0]  x8,  y8;
   logic [15:0] p8;
   logic [15:0] x16, y16;
   logic [31:0] p16;

   vcm_mul #(.WIDTH(8)) dut (
      .x    (x8),
      .y    (y8),
      .prod (p8)
   );

   vcm_mul #(.WIDTH(16)) dut16 (
      .x    (x16),
      .y    (y16),
      .prod (p16)
   );

   task automatic check8(input string req, input logic [15:0] exp);
      checks++;
      if (p8 !== exp) begin
         errors++;
         $display("FAIL %s: x=%0d y=%0d actual %0d expected %0d", req, x8, y8, p8, exp);
      end
   endtask

   task automatic check16(input string req, input logic [31:0] exp);
      checks++;
      if (p16 !== exp) begin
         errors++;
         $display("FAIL %s: x=%0d y=%0d actual %0d expected %0d", req, x16, y16, p16, exp);
      end
   endtask

   // drive on rising edge, sample on falling edge
   task automatic apply8(input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      x8 = a;
      y8 = b;
      @(negedge clk);
   endtask

   task automatic apply16(input logic [15:0] a, input logic [15:0] b);
      @(posedge clk);
      x16 = a;
      y16 = b;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      x8 = '0; y8 = '0; x16 = '0; y16 = '0;
      @(negedge clk);
      // R4: initial zero operands
      check8("R4", 16'd0);

      // R8: stated cases
      apply8(8'd136, 8'd119); check8("R8", 16'd16184);
      apply8(8'd141, 8'd124); check8("R8", 16'd17484);

      // R3: full-height corner
      apply8(8'd255, 8'd255); check8("R3", 16'd65025);

      // R4 / R5 corners
      apply8(8'd0, 8'd200);   check8("R4", 16'd0);
      apply8(8'd77, 8'd0);    check8("R4", 16'd0);
      apply8(8'd1, 8'd213);   check8("R5", 16'd213);
      apply8(8'd213, 8'd1);   check8("R5", 16'd213);

      // R2: output follows an input change with no edge in between
      @(posedge clk);
      #2 x8 = 8'd12; y8 = 8'd11;
      #1 check8("R2", 16'd132);
      #1 y8 = 8'd13;
      #1 check8("R2", 16'd156);

      // R7: single-bit operands land in column i+j
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            apply8(8'(1 << i), 8'(1 << j));
            check8("R7", 16'(1 << (i + j)));
         end
      end

      // R1 / R6: exhaustive sweep of the 8-bit build
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            apply8(8'(a), 8'(b));
            check8("R1", 16'(a * b));
         end
      end

      // R9: 16-bit build, corners plus random samples
      apply16(16'hFFFF, 16'hFFFF); check16("R9", 32'hFFFE_0001);
      apply16(16'd1, 16'd40000);   check16("R9", 32'd40000);
      apply16(16'd0, 16'd12345);   check16("R9", 32'd0);
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] ra, rb;
         ra = 16'($urandom);
         rb = 16'($urandom);
         apply16(ra, rb);
         check16("R9", {16'd0, ra} * {16'd0, rb});
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule